// File: doc/BRIEF.md
# Immediate-prefix and predicated-skip decoder

This block sits between instruction fetch and execute in a core with 16-bit instructions. It accepts one instruction word per cycle over a valid/ready stream. Prefix words are not passed on. Instead, their 12-bit literals are folded into a hidden accumulator. The next instruction that carries an extendable field is then emitted with a full-width immediate, built from the accumulator and that field. No register-file port and no ALU cycle are spent on building the constant.

Compare-and-skip words (bits 15:14 = 01) are passed downstream together with their own extended immediate. The outcome of each comparison comes back on `cond_pass` in the cycle that word is accepted. A failed test in a chain of such words marks the next real instruction (any word that is neither a prefix nor a compare-and-skip) as squashed. The prefix accumulator and the pending-skip bit can be read out and reloaded, so that they survive an interrupt.

The output is a single register stage. `in_ready` is high when that stage is empty or is being drained in the same cycle (`out_ready` high), and restore is not in progress. While `out_valid` is high and `out_ready` is low, the output contents are held. Prefix words are consumed without producing output.

Top module: `pfx_skip_decoder`

## Requirements
- R1: A word is accepted when `in_valid` and `in_ready` are both high. `in_ready` equals `(!out_valid || out_ready) && !rs_load`. While `out_valid` is high and `out_ready` is low, `out_insn`, `out_imm` and `out_exec` stay unchanged.
- R2: A word with bits 15:12 = 1110 is a prefix. It produces no output. It updates the accumulator to (accumulator << 12) | bits 11:0, keeping only the low 32 bits.
- R3: When at least one prefix precedes a word, `out_imm` is (accumulator << W) | field, truncated to 32 bits. The field is bits 3:0 (W=4) for ALU (15:14=00), compare-and-skip (01), load/store (15:13=100/101) and coprocessor-load (15:12=1100) words. It is bits 11:0 (W=12) for branch (1101) and coprocessor-instruction (1111) words. Prefixed values are never sign-extended.
- R4: With no preceding prefix, 4-bit fields and the coprocessor-instruction field are zero-extended, and the 12-bit branch displacement is sign-extended from bit 11.
- R5: `cond_pass` is sampled when a compare-and-skip word is accepted. A value of 0 causes the next real instruction to leave with `out_exec` = 0. The compare-and-skip word itself always leaves with `out_exec` = 1.
- R6: Stacked compare-and-skip words (with or without their own prefixes) squash the following real instruction if any of them failed. If all of them passed, the instruction leaves with `out_exec` = 1.
- R7: Accepting any non-prefix word clears the accumulator and its seen flag, so prefixes bind only to the next non-prefix word. Accepting a real instruction also clears the pending skip.
- R8: `sv_acc`, `sv_seen` and `sv_skip` show the accumulator, the prefix-seen flag and the pending skip. A high `rs_load` loads them from `rs_acc`, `rs_seen` and `rs_skip` at the clock edge, and no input word is accepted in that cycle.
- R9: After reset, `out_valid` is 0, `in_ready` is 1, and all saved state reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word valid |
| in_ready | output | 1 | Decoder can accept a word |
| in_insn | input | 16 | Instruction word |
| cond_pass | input | 1 | Comparison outcome for an accepted compare-and-skip word |
| out_valid | output | 1 | Decoded instruction valid |
| out_ready | input | 1 | Execute takes the decoded instruction |
| out_insn | output | 16 | Decoded instruction word |
| out_imm | output | 32 | Extended immediate or displacement |
| out_exec | output | 1 | 1 = execute, 0 = squash |
| sv_acc | output | 32 | Current prefix accumulator |
| sv_seen | output | 1 | At least one prefix is held |
| sv_skip | output | 1 | Next real instruction will be squashed |
| rs_load | input | 1 | Load saved state |
| rs_acc | input | 32 | Accumulator value to restore |
| rs_seen | input | 1 | Prefix-seen flag to restore |
| rs_skip | input | 1 | Pending skip to restore |

## Verification
The assertions check on every cycle that the output stage holds still under back-pressure and that a prefix never creates an output. They also check that a failed comparison sets the pending skip, that a consumed real instruction clears both the accumulator and the skip, and that compare-and-skip words always leave unsquashed. Only the bench scenarios can show that the merged immediate has the right value for each instruction class. The same holds for chained prefixes that overflow 32 bits, stacked comparisons that mix passes and failures, and restored state taking effect on the next instruction.

// File: rtl/pfx_skip_pkg.sv
package pfx_skip_pkg;
  localparam int INSN_W = 16;

  typedef enum logic [2:0] {
    K_ALU, K_COND, K_MEM, K_XLD, K_BRA, K_PFX, K_XINS
  } insn_kind_e;

  function automatic insn_kind_e classify(input logic [INSN_W-1:0] w);
    insn_kind_e k;
    case (w[15:14])
      2'b00: k = K_ALU;
      2'b01: k = K_COND;
      2'b10: k = K_MEM;
      default: begin
        case (w[13:12])
          2'b00:   k = K_XLD;
          2'b01:   k = K_BRA;
          2'b10:   k = K_PFX;
          default: k = K_XINS;
        endcase
      end
    endcase
    return k;
  endfunction
endpackage

// File: rtl/pfx_accum.sv
module pfx_accum #(
  parameter int DATA_W = 32,
  parameter int PFX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              clr,
  input  logic [PFX_W-1:0]  lit,
  input  logic              rs_load,
  input  logic [DATA_W-1:0] rs_acc,
  input  logic              rs_seen,
  output logic [DATA_W-1:0] acc,
  output logic              seen
);
  localparam int KEEP_W = DATA_W - PFX_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      seen <= 1'b0;
    end else if (rs_load) begin
      acc  <= rs_acc;
      seen <= rs_seen;
    end else if (push) begin
      acc  <= {acc[KEEP_W-1:0], lit};
      seen <= 1'b1;
    end else if (clr) begin
      acc  <= '0;
      seen <= 1'b0;
    end
  end

  // R2
  pushed_lit_lands_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !rs_load) |=> (seen && acc[PFX_W-1:0] == $past(lit)));
endmodule

// File: rtl/skip_track.sv
module skip_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_fire,
  input  logic cond_pass,
  input  logic real_fire,
  input  logic rs_load,
  input  logic rs_skip,
  output logic skip_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         skip_q <= 1'b0;
    else if (rs_load)   skip_q <= rs_skip;
    else if (cond_fire) skip_q <= skip_q | ~cond_pass;
    else if (real_fire) skip_q <= 1'b0;
  end

  // R5
  failed_test_arms_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_fire && !cond_pass && !rs_load) |=> skip_q);

  // R6
  pass_keeps_prior_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_fire && skip_q && !rs_load) |=> skip_q);
endmodule

// File: rtl/field_extend.sv
module field_extend
  import pfx_skip_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHORT_W = 4,
  parameter int LONG_W  = 12
) (
  input  logic [INSN_W-1:0] insn,
  input  insn_kind_e        kind,
  input  logic [DATA_W-1:0] acc,
  input  logic              seen,
  output logic [DATA_W-1:0] imm
);
  localparam int SKEEP = DATA_W - SHORT_W;
  localparam int LKEEP = DATA_W - LONG_W;

  logic [DATA_W-1:0] short_plain, short_pfx, long_zero, long_sign, long_pfx;

  always_comb begin
    short_plain = {{SKEEP{1'b0}}, insn[SHORT_W-1:0]};
    short_pfx   = {acc[SKEEP-1:0], insn[SHORT_W-1:0]};
    long_zero   = {{LKEEP{1'b0}}, insn[LONG_W-1:0]};
    long_sign   = {{LKEEP{insn[LONG_W-1]}}, insn[LONG_W-1:0]};
    long_pfx    = {acc[LKEEP-1:0], insn[LONG_W-1:0]};
    case (kind)
      K_BRA:   imm = seen ? long_pfx : long_sign;
      K_XINS:  imm = seen ? long_pfx : long_zero;
      K_PFX:   imm = '0;
      default: imm = seen ? short_pfx : short_plain;
    endcase
  end
endmodule

// File: rtl/pfx_skip_decoder.sv
module pfx_skip_decoder
  import pfx_skip_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PFX_W   = 12,
  parameter int SHORT_W = 4,
  parameter int LONG_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_insn,
  input  logic              cond_pass,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [15:0]       out_insn,
  output logic [DATA_W-1:0] out_imm,
  output logic              out_exec,
  output logic [DATA_W-1:0] sv_acc,
  output logic              sv_seen,
  output logic              sv_skip,
  input  logic              rs_load,
  input  logic [DATA_W-1:0] rs_acc,
  input  logic              rs_seen,
  input  logic              rs_skip
);
  insn_kind_e        kind;
  logic              accept, pfx_fire, cond_fire, real_fire, emit;
  logic [DATA_W-1:0] acc, imm_next;
  logic              seen, skip_q;

  assign kind      = classify(in_insn);
  assign in_ready  = (!out_valid || out_ready) && !rs_load;
  assign accept    = in_valid && in_ready;
  assign pfx_fire  = accept && (kind == K_PFX);
  assign cond_fire = accept && (kind == K_COND);
  assign real_fire = accept && (kind != K_PFX) && (kind != K_COND);
  assign emit      = cond_fire || real_fire;

  pfx_accum #(.DATA_W(DATA_W), .PFX_W(PFX_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .push(pfx_fire), .clr(emit),
    .lit(in_insn[PFX_W-1:0]), .rs_load(rs_load), .rs_acc(rs_acc),
    .rs_seen(rs_seen), .acc(acc), .seen(seen)
  );

  skip_track u_skip (
    .clk(clk), .rst_n(rst_n), .cond_fire(cond_fire), .cond_pass(cond_pass),
    .real_fire(real_fire), .rs_load(rs_load), .rs_skip(rs_skip), .skip_q(skip_q)
  );

  field_extend #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_ext (
    .insn(in_insn), .kind(kind), .acc(acc), .seen(seen), .imm(imm_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_insn  <= '0;
      out_imm   <= '0;
      out_exec  <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_insn  <= in_insn;
      out_imm   <= imm_next;
      out_exec  <= cond_fire ? 1'b1 : !skip_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign sv_acc  = acc;
  assign sv_seen = seen;
  assign sv_skip = skip_q;

  // R1
  stall_holds_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_insn) && $stable(out_imm) && $stable(out_exec)));

  // R2
  prefix_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_fire && out_ready) |=> !out_valid);

  // R5
  cond_never_squashed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_insn[15:14] == 2'b01) |-> out_exec);

  // R7
  real_clears_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (real_fire && !rs_load) |=> (!sv_seen && !sv_skip && sv_acc == '0));

  // R8
  restore_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_load |=> (sv_acc == $past(rs_acc) && sv_skip == $past(rs_skip)));
endmodule

// File: tb/pfx_skip_decoder_test.sv
module pfx_skip_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, cond_pass = 1'b1, out_ready = 1'b1;
  logic [15:0] in_insn = '0;
  logic        in_ready, out_valid, out_exec, sv_seen, sv_skip;
  logic [15:0] out_insn;
  logic [31:0] out_imm, sv_acc;
  logic        rs_load = 1'b0, rs_seen = 1'b0, rs_skip = 1'b0;
  logic [31:0] rs_acc = '0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pfx_skip_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .cond_pass(cond_pass), .out_valid(out_valid),
    .out_ready(out_ready), .out_insn(out_insn), .out_imm(out_imm),
    .out_exec(out_exec), .sv_acc(sv_acc), .sv_seen(sv_seen), .sv_skip(sv_skip),
    .rs_load(rs_load), .rs_acc(rs_acc), .rs_seen(rs_seen), .rs_skip(rs_skip)
  );

  // fields: insn, cond_pass, output expected, exec expected, imm expected
  localparam int NV = 29;
  localparam logic [50:0] VEC [0:NV-1] = '{
    {16'h1237, 1'b1, 1'b1, 1'b1, 32'h0000_0007}, // R4 alu zero-ext
    {16'hEABC, 1'b1, 1'b0, 1'b0, 32'h0},         // R2 prefix, no output
    {16'h0125, 1'b1, 1'b1, 1'b1, 32'h0000_ABC5}, // R3 one prefix
    {16'hE123, 1'b1, 1'b0, 1'b0, 32'h0},         // R2
    {16'hE456, 1'b1, 1'b0, 1'b0, 32'h0},         // R2
    {16'hE789, 1'b1, 1'b0, 1'b0, 32'h0},         // R2
    {16'h000F, 1'b1, 1'b1, 1'b1, 32'h3456_789F}, // R3 three prefixes, truncation
    {16'hDFFE, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFE}, // R4 branch sign-ext
    {16'hE001, 1'b1, 1'b0, 1'b0, 32'h0},         // R2
    {16'hD800, 1'b1, 1'b1, 1'b1, 32'h0000_1800}, // R3 branch prefixed, no sign-ext
    {16'h8AB9, 1'b1, 1'b1, 1'b1, 32'h0000_0009}, // R4 load
    {16'hA123, 1'b1, 1'b1, 1'b1, 32'h0000_0003}, // R4 store
    {16'hC12A, 1'b1, 1'b1, 1'b1, 32'h0000_000A}, // R4 coprocessor load
    {16'hFABC, 1'b1, 1'b1, 1'b1, 32'h0000_0ABC}, // R4 coprocessor insn
    {16'h4125, 1'b1, 1'b1, 1'b1, 32'h0000_0005}, // R5 passing cond
    {16'h0001, 1'b1, 1'b1, 1'b1, 32'h0000_0001}, // R5 executes
    {16'h4002, 1'b0, 1'b1, 1'b1, 32'h0000_0002}, // R5 failing cond still exec=1
    {16'hE00F, 1'b1, 1'b0, 1'b0, 32'h0},         // R2
    {16'h0003, 1'b1, 1'b1, 1'b0, 32'h0000_00F3}, // R5 squashed with its prefix
    {16'h0004, 1'b1, 1'b1, 1'b1, 32'h0000_0004}, // R7 skip cleared
    {16'h4011, 1'b1, 1'b1, 1'b1, 32'h0000_0001}, // R6 stack: pass
    {16'hE0AA, 1'b1, 1'b0, 1'b0, 32'h0},         // R6 prefix on cond
    {16'h4022, 1'b0, 1'b1, 1'b1, 32'h0000_0AA2}, // R6 stack: fail, prefixed cond
    {16'h4033, 1'b1, 1'b1, 1'b1, 32'h0000_0003}, // R6 stack: pass
    {16'hD005, 1'b1, 1'b1, 1'b0, 32'h0000_0005}, // R6 branch squashed
    {16'hD006, 1'b1, 1'b1, 1'b1, 32'h0000_0006}, // R6 next branch runs
    {16'hE111, 1'b1, 1'b0, 1'b0, 32'h0},         // R7
    {16'h4004, 1'b1, 1'b1, 1'b1, 32'h0000_1114}, // R7 cond takes prefix
    {16'h0005, 1'b1, 1'b1, 1'b1, 32'h0000_0005}  // R7 prefix not reused
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!out_valid && in_ready, "R9 out_valid/in_ready", {out_valid, in_ready}, 2'b01);
    chk(sv_acc == 0 && !sv_seen && !sv_skip, "R9 saved state",
        {sv_acc, sv_seen, sv_skip}, 0);

    for (int i = 0; i < NV; i++) begin
      in_valid  = 1'b1;
      in_insn   = VEC[i][50:35];
      cond_pass = VEC[i][34];
      @(negedge clk);
      if (VEC[i][33])
        chk(out_valid && out_insn == VEC[i][50:35] && out_exec == VEC[i][32]
            && out_imm == VEC[i][31:0], $sformatf("R3/R4/R5/R6/R7 vector %0d", i),
            {out_valid, out_exec, out_insn, out_imm},
            {1'b1, VEC[i][32], VEC[i][50:35], VEC[i][31:0]});
      else
        chk(!out_valid, $sformatf("R2 vector %0d no output", i), out_valid, 0);
    end
    in_valid = 1'b0;
    @(negedge clk);

    // R1 back-pressure
    out_ready = 1'b0; in_valid = 1'b1; in_insn = 16'h0009;
    @(negedge clk);
    chk(out_valid && out_imm == 9 && !in_ready, "R1 stalled capture",
        {out_valid, in_ready, out_imm}, {2'b10, 32'h9});
    in_insn = 16'h000A;
    @(negedge clk);
    chk(out_insn == 16'h0009 && out_imm == 9 && out_valid, "R1 held under stall",
        out_insn, 16'h0009);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid && out_insn == 16'h000A && out_imm == 32'hA, "R1 drain and accept",
        out_insn, 16'h000A);
    in_valid = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R1 empty after drain", out_valid, 0);

    // R8 save / restore
    in_valid = 1'b1; in_insn = 16'hE123;
    @(negedge clk);
    chk(sv_acc == 32'h123 && sv_seen, "R8 saved accumulator", sv_acc, 32'h123);
    in_insn = 16'h4000; cond_pass = 1'b0;
    @(negedge clk);
    chk(sv_skip && !sv_seen && sv_acc == 0, "R7 cond clears prefix, arms skip",
        {sv_acc, sv_seen, sv_skip}, 2'b01);
    cond_pass = 1'b1;
    in_insn = 16'h0007; rs_load = 1'b1; rs_acc = 32'hABC; rs_seen = 1'b1; rs_skip = 1'b0;
    #1;
    chk(!in_ready, "R8 input blocked during restore", in_ready, 0);
    @(negedge clk);
    rs_load = 1'b0;
    chk(sv_acc == 32'hABC && sv_seen && !sv_skip, "R8 restored state",
        {sv_acc, sv_seen, sv_skip}, {32'hABC, 2'b10});
    in_insn = 16'h0001;
    @(negedge clk);
    chk(out_valid && out_insn == 16'h0001 && out_imm == 32'hABC1 && out_exec,
        "R8 restored prefix applied", {out_insn, out_imm}, {16'h0001, 32'hABC1});
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule